// File: doc/BRIEF.md
# Converter Output Demultiplexer and Data-Clock Formatter

This block sits behind a dual-channel sampler. On every clock edge it takes one I word and one Q word and places them on four output lanes: a primary and a delayed lane for I, and the same pair for Q. Two routing choices set where the words go. One selects interleaved operation, where the two channels form a single stream. The other selects demultiplexing, which halves the word rate on each lane. Lanes that the current routing does not use have their output-enable flag low and read zero. A pad stage outside the block turns that into high impedance.

Alongside the data the block produces a data-clock waveform. Each clock cycle is split into two half-cycle phase flags: bit 1 is the first half and bit 0 the second half. In single-rate mode the data clock has one period per output word, and one configuration bit picks whether words change on its rising or its falling edge. In double-rate mode the data clock runs at half the word rate, with words changing on both edges at zero phase. That same configuration bit has a second role in double-rate mode: there it selects demultiplexing. A realign input freezes the block, latches a new configuration, and restarts the data clock after a fixed countdown.

Top module: `cvt_out_formatter`

## Requirements
- R1: The mode inputs (`mode_ilv`, `mode_dmx_sdr`, `mode_ddr`, `mode_shared`) are latched only on edges where `dclk_realign` is high. Changing them while `dclk_realign` is low has no effect on `lane_oe`, the lanes or the data clock.
- R2: While `dclk_realign` is high, `dclk_wave` is 2'b00 and the primary lanes hold their values. Call the first edge that samples `dclk_realign` low edge 1. Outputs stay frozen and `dclk_wave` stays 2'b00 until edge D. At edge D the first lane update and the first data-clock activity appear. D is 4 when double-rate, demultiplexed and non-interleaved are all selected; otherwise D is 3.
- R3: Without demultiplexing, every active edge loads `lane_p0` with the I word and `lane_p1` with the Q word sampled at that edge. `lane_oe` is 4'b0101, and the delayed lanes read zero.
- R4: In 1:2 demultiplex (non-interleaved), lanes update only on every second active edge, starting at edge D. `lane_p0d` and `lane_p1d` get the I and Q words from the previous edge. `lane_p0` and `lane_p1` get the words from the current edge. `lane_oe` is 4'b1111.
- R5: In 1:4 demultiplex (interleaved), on the same group edges as R4, the stream order is previous I, previous Q, current I, current Q. These go to `lane_p0d`, `lane_p0`, `lane_p1d` and `lane_p1` respectively.
- R6: In single-rate mode without demultiplexing, every active cycle shows `dclk_wave` = 2'b10 when rising-edge output is chosen (`mode_shared`=1) and 2'b01 when falling-edge output is chosen.
- R7: In single-rate mode with demultiplexing, a group-update cycle shows 2'b11 with rising-edge output and 2'b00 with falling-edge output. The cycle between group updates shows the inverse.
- R8: In double-rate mode without demultiplexing, `dclk_wave` alternates 2'b11, 2'b00, starting with 2'b11 at edge D.
- R9: In double-rate mode with demultiplexing, `dclk_wave` repeats 2'b11, 2'b11, 2'b00, 2'b00, starting at edge D.
- R10: In double-rate mode, `mode_shared` selects demultiplexing and `mode_dmx_sdr` is ignored. In single-rate mode, `mode_dmx_sdr` selects demultiplexing and `mode_shared` selects the output edge.
- R11: Asynchronous reset clears all lanes and `dclk_wave` to zero and sets `lane_oe` to 4'b0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| samp_i | input | 8 | I-channel word for this cycle |
| samp_q | input | 8 | Q-channel word for this cycle |
| mode_ilv | input | 1 | Interleaved operation select |
| mode_dmx_sdr | input | 1 | Demultiplex select used in single-rate mode |
| mode_ddr | input | 1 | Double-rate data clock select |
| mode_shared | input | 1 | Edge select (single-rate) or demultiplex select (double-rate) |
| dclk_realign | input | 1 | Data-clock realign; mode latch enable |
| lane_p0 | output | 8 | Primary I-side lane |
| lane_p0d | output | 8 | Delayed I-side lane |
| lane_p1 | output | 8 | Primary Q-side lane |
| lane_p1d | output | 8 | Delayed Q-side lane |
| lane_oe | output | 4 | Lane enables: bit0 p0, bit1 p0d, bit2 p1, bit3 p1d |
| dclk_wave | output | 2 | Data-clock level: bit1 first half-cycle, bit0 second half |

## Verification
The assertions take for granted that `dclk_realign` and the mode inputs are synchronous to `clk`, and that `rst_n` is released away from a clock edge. They also assume mode inputs carry meaning only when a realign is in progress. The stimulus changes every input one nanosecond after the falling clock edge. It holds realign high for two edges before each run, and during each run it drives the complemented mode bits. Any leak of those pins into the latched configuration therefore changes the enables, lane contents or data-clock pattern.

// File: rtl/cvt_fmt_pkg.sv
package cvt_fmt_pkg;

  // Routing selection: bit 1 = demultiplex, bit 0 = interleave.
  typedef enum logic [1:0] {
    ROUTE_SPLIT = 2'b00,
    ROUTE_ILV   = 2'b01,
    ROUTE_DMX2  = 2'b10,
    ROUTE_DMX4  = 2'b11
  } route_e;

  typedef struct packed {
    logic   ddr;
    logic   edge_rise;
    route_e route;
  } fmt_cfg_t;

  localparam int unsigned LANES    = 4;
  localparam int unsigned LANE_P0  = 0;
  localparam int unsigned LANE_P0D = 1;
  localparam int unsigned LANE_P1  = 2;
  localparam int unsigned LANE_P1D = 3;

  function automatic logic route_dmx(input route_e r);
    return r[1];
  endfunction

endpackage

// File: rtl/cvt_fmt_sync_ctrl.sv
module cvt_fmt_sync_ctrl
  import cvt_fmt_pkg::*;
#(
  parameter int unsigned DELAY_BASE = 3,
  parameter int unsigned DELAY_LONG = 4,
  parameter int unsigned SEQ_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             realign,
  input  logic             mode_ilv,
  input  logic             mode_dmx_sdr,
  input  logic             mode_ddr,
  input  logic             mode_shared,
  output fmt_cfg_t         cfg,
  output fmt_cfg_t         cfg_next,
  output logic             active,
  output logic [SEQ_W-1:0] seq
);

  localparam int unsigned CNT_W = $clog2(DELAY_LONG);

  fmt_cfg_t         cfg_q, cfg_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [SEQ_W-1:0] seq_q, seq_nx;
  logic             eff_dmx;

  // Shared bit selects demux only in double-rate mode.
  assign eff_dmx = mode_ddr ? mode_shared : mode_dmx_sdr;

  always_comb begin
    cfg_nx = cfg_q;
    cnt_nx = cnt_q;
    seq_nx = seq_q;
    if (realign) begin
      cfg_nx.ddr       = mode_ddr;
      cfg_nx.edge_rise = mode_ddr ? 1'b0 : mode_shared;
      cfg_nx.route     = route_e'({eff_dmx, mode_ilv});
      cnt_nx = (mode_ddr && eff_dmx && !mode_ilv) ? CNT_W'(DELAY_LONG - 1)
                                                   : CNT_W'(DELAY_BASE - 1);
      seq_nx = '0;
    end else if (cnt_q != '0) begin
      cnt_nx = cnt_q - CNT_W'(1);
    end else begin
      seq_nx = seq_q + SEQ_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= CNT_W'(DELAY_BASE - 1);
      seq_q <= '0;
    end else begin
      cfg_q <= cfg_nx;
      cnt_q <= cnt_nx;
      seq_q <= seq_nx;
    end
  end

  assign cfg      = cfg_q;
  assign cfg_next = cfg_nx;
  assign active   = !realign && (cnt_q == '0);
  assign seq      = seq_q;

endmodule

// File: rtl/cvt_fmt_lane_router.sv
module cvt_fmt_lane_router
  import cvt_fmt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] samp_i,
  input  logic [DW-1:0] samp_q,
  input  logic          realign,
  input  logic          active,
  input  logic          group_edge,
  input  fmt_cfg_t      cfg,
  input  fmt_cfg_t      cfg_next,
  output logic [DW-1:0] lane_out [LANES]
);

  logic [DW-1:0] prev_i, prev_q;
  logic [DW-1:0] lane_q  [LANES];
  logic [DW-1:0] lane_d  [LANES];
  logic          lane_we [LANES];

  // One-edge history of both channels; the earlier word feeds delayed lanes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_i <= '0;
      prev_q <= '0;
    end else begin
      prev_i <= samp_i;
      prev_q <= samp_q;
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_we[l] = 1'b0;
      lane_d[l]  = '0;
    end
    if (realign) begin
      if (!route_dmx(cfg_next.route)) begin
        lane_we[LANE_P0D] = 1'b1;
        lane_we[LANE_P1D] = 1'b1;
      end
    end else if (active) begin
      unique case (cfg.route)
        ROUTE_SPLIT, ROUTE_ILV: begin
          lane_we[LANE_P0] = 1'b1;  lane_d[LANE_P0] = samp_i;
          lane_we[LANE_P1] = 1'b1;  lane_d[LANE_P1] = samp_q;
        end
        ROUTE_DMX2: begin
          for (int l = 0; l < LANES; l++) lane_we[l] = group_edge;
          lane_d[LANE_P0D] = prev_i;
          lane_d[LANE_P0]  = samp_i;
          lane_d[LANE_P1D] = prev_q;
          lane_d[LANE_P1]  = samp_q;
        end
        ROUTE_DMX4: begin
          for (int l = 0; l < LANES; l++) lane_we[l] = group_edge;
          lane_d[LANE_P0D] = prev_i;
          lane_d[LANE_P0]  = prev_q;
          lane_d[LANE_P1D] = samp_i;
          lane_d[LANE_P1]  = samp_q;
        end
        default: ;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[l] <= '0;
      end else if (lane_we[l]) begin
        lane_q[l] <= lane_d[l];
      end
    end
    assign lane_out[l] = lane_q[l];
  end

endmodule

// File: rtl/cvt_fmt_dclk_gen.sv
module cvt_fmt_dclk_gen
  import cvt_fmt_pkg::*;
#(
  parameter int unsigned SEQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SEQ_W-1:0] seq,
  input  fmt_cfg_t         cfg,
  output logic [1:0]       wave
);

  logic [1:0] wave_q, wave_nx;
  logic       hi;

  always_comb begin
    hi      = 1'b0;
    wave_nx = 2'b00;
    if (active) begin
      unique case ({cfg.ddr, route_dmx(cfg.route)})
        2'b00: wave_nx = cfg.edge_rise ? 2'b10 : 2'b01;
        2'b01: begin hi = (seq[0] != cfg.edge_rise); wave_nx = {hi, hi}; end
        2'b10: begin hi = ~seq[0];                   wave_nx = {hi, hi}; end
        2'b11: begin hi = ~seq[1];                   wave_nx = {hi, hi}; end
        default: wave_nx = 2'b00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 2'b00;
    else        wave_q <= wave_nx;
  end

  assign wave = wave_q;

endmodule

// File: rtl/cvt_out_formatter.sv
module cvt_out_formatter
  import cvt_fmt_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DELAY_BASE = 3,
  parameter int unsigned DELAY_LONG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] samp_i,
  input  logic [DATA_W-1:0] samp_q,
  input  logic              mode_ilv,
  input  logic              mode_dmx_sdr,
  input  logic              mode_ddr,
  input  logic              mode_shared,
  input  logic              dclk_realign,
  output logic [DATA_W-1:0] lane_p0,
  output logic [DATA_W-1:0] lane_p0d,
  output logic [DATA_W-1:0] lane_p1,
  output logic [DATA_W-1:0] lane_p1d,
  output logic [3:0]        lane_oe,
  output logic [1:0]        dclk_wave
);

  localparam int unsigned SEQ_W = 2;

  fmt_cfg_t          cfg, cfg_next;
  logic              active;
  logic [SEQ_W-1:0]  seq;
  logic [DATA_W-1:0] lanes [LANES];

  cvt_fmt_sync_ctrl #(
    .DELAY_BASE (DELAY_BASE),
    .DELAY_LONG (DELAY_LONG),
    .SEQ_W      (SEQ_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .realign      (dclk_realign),
    .mode_ilv     (mode_ilv),
    .mode_dmx_sdr (mode_dmx_sdr),
    .mode_ddr     (mode_ddr),
    .mode_shared  (mode_shared),
    .cfg          (cfg),
    .cfg_next     (cfg_next),
    .active       (active),
    .seq          (seq)
  );

  cvt_fmt_lane_router #(.DW(DATA_W)) u_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_i     (samp_i),
    .samp_q     (samp_q),
    .realign    (dclk_realign),
    .active     (active),
    .group_edge (~seq[0]),
    .cfg        (cfg),
    .cfg_next   (cfg_next),
    .lane_out   (lanes)
  );

  cvt_fmt_dclk_gen #(.SEQ_W(SEQ_W)) u_dclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .seq    (seq),
    .cfg    (cfg),
    .wave   (dclk_wave)
  );

  assign lane_p0  = lanes[LANE_P0];
  assign lane_p0d = lanes[LANE_P0D];
  assign lane_p1  = lanes[LANE_P1];
  assign lane_p1d = lanes[LANE_P1D];
  assign lane_oe  = {route_dmx(cfg.route), 1'b1, route_dmx(cfg.route), 1'b1};

endmodule

// File: rtl/cvt_fmt_checker.sv
module cvt_fmt_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dclk_realign,
  input logic [DATA_W-1:0] lane_p0,
  input logic [DATA_W-1:0] lane_p0d,
  input logic [DATA_W-1:0] lane_p1,
  input logic [DATA_W-1:0] lane_p1d,
  input logic [3:0]        lane_oe,
  input logic [1:0]        dclk_wave
);

  assert_wave_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_realign |=> (dclk_wave == 2'b00));

  assert_lanes_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_realign |=> ($stable(lane_p0) && $stable(lane_p1)));

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dclk_realign |=> $stable(lane_oe));

  assert_idle_lanes_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_oe[1] |-> (lane_p0d == '0 && lane_p1d == '0));

  assert_rise_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_wave == 2'b10 && !dclk_realign) |=> (dclk_wave == 2'b10));

  assert_fall_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_wave == 2'b01 && !dclk_realign) |=> (dclk_wave == 2'b01));

endmodule

bind cvt_out_formatter cvt_fmt_checker #(.DATA_W(DATA_W)) u_fmt_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dclk_realign (dclk_realign),
  .lane_p0      (lane_p0),
  .lane_p0d     (lane_p0d),
  .lane_p1      (lane_p1),
  .lane_p1d     (lane_p1d),
  .lane_oe      (lane_oe),
  .dclk_wave    (dclk_wave)
);

// File: tb/tb_cvt_out_formatter.sv
`timescale 1ns/1ps
module tb_cvt_out_formatter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] samp_i, samp_q;
  logic       mode_ilv, mode_dmx_sdr, mode_ddr, mode_shared, dclk_realign;
  logic [7:0] lane_p0, lane_p0d, lane_p1, lane_p1d;
  logic [3:0] lane_oe;
  logic [1:0] dclk_wave;

  always #4 clk = ~clk;

  cvt_out_formatter dut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .samp_q(samp_q),
    .mode_ilv(mode_ilv), .mode_dmx_sdr(mode_dmx_sdr), .mode_ddr(mode_ddr),
    .mode_shared(mode_shared), .dclk_realign(dclk_realign),
    .lane_p0(lane_p0), .lane_p0d(lane_p0d), .lane_p1(lane_p1), .lane_p1d(lane_p1d),
    .lane_oe(lane_oe), .dclk_wave(dclk_wave)
  );

  typedef struct packed {
    logic [31:0] lanes;   // {p1d, p1, p0d, p0}
    logic [3:0]  oe;
    logic [1:0]  wave;
    logic [3:0]  tag_l;
    logic [3:0]  tag_w;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  int    smp    = 0;
  logic [7:0] e_lane [4];
  logic [7:0] prev_i, prev_q;

  function automatic string req_name(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compares the outputs of each rising edge half a cycle later.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(req_name(it.tag_l), {lane_p1d, lane_p1, lane_p0d, lane_p0}, it.lanes);
        check(req_name(it.tag_w), {30'd0, dclk_wave}, {30'd0, it.wave});
        check("R1", {28'd0, lane_oe}, {28'd0, it.oe});
      end
    end
  end

  // Driver: one configuration run with expected values pushed per edge.
  task automatic run_mode(input logic ilv, input logic dsdr, input logic ddr,
                          input logic sh, input int ncyc,
                          input logic [3:0] tl, input logic [3:0] tw);
    logic dmx;
    int   dly;
    dmx = ddr ? sh : dsdr;
    dly = (ddr && dmx && !ilv) ? 4 : 3;
    for (int k = -1; k <= ncyc; k++) begin
      item_t it;
      logic [7:0] ci, cq;
      logic rl;
      int   a;
      rl = (k <= 0);
      @(negedge clk); #1;
      ci = 8'(2 * smp);
      cq = 8'(2 * smp + 1);
      samp_i = ci;
      samp_q = cq;
      dclk_realign = rl;
      // Complemented mode pins while running must be ignored (R1).
      mode_ilv     = rl ? ilv  : ~ilv;
      mode_dmx_sdr = rl ? dsdr : ~dsdr;
      mode_ddr     = rl ? ddr  : ~ddr;
      mode_shared  = rl ? sh   : ~sh;
      it.wave  = 2'b00;
      it.tag_l = 4'd2;
      it.tag_w = 4'd2;
      if (rl) begin
        if (!dmx) begin e_lane[1] = 8'd0; e_lane[3] = 8'd0; end
      end else if (k >= dly) begin
        a = k - dly;
        it.tag_l = tl;
        it.tag_w = tw;
        if (!dmx) begin
          e_lane[0] = ci; e_lane[2] = cq;
          it.wave = ddr ? ((a % 2 == 0) ? 2'b11 : 2'b00) : (sh ? 2'b10 : 2'b01);
        end else begin
          if (a % 2 == 0) begin
            if (!ilv) begin
              e_lane[1] = prev_i; e_lane[0] = ci; e_lane[3] = prev_q; e_lane[2] = cq;
            end else begin
              e_lane[1] = prev_i; e_lane[0] = prev_q; e_lane[3] = ci; e_lane[2] = cq;
            end
          end
          if (ddr) it.wave = (a % 4 < 2) ? 2'b11 : 2'b00;
          else     it.wave = (((a % 2) == 0) == (sh == 1'b1)) ? 2'b11 : 2'b00;
        end
      end
      it.lanes = {e_lane[3], e_lane[2], e_lane[1], e_lane[0]};
      it.oe    = {dmx, 1'b1, dmx, 1'b1};
      sb.push_back(it);
      prev_i = ci;
      prev_q = cq;
      smp++;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    dclk_realign = 1'b1;
    mode_ilv = 0; mode_dmx_sdr = 0; mode_ddr = 0; mode_shared = 0;
    samp_i = 8'h00; samp_q = 8'h00;
    for (int l = 0; l < 4; l++) e_lane[l] = 8'd0;
    prev_i = 8'd0; prev_q = 8'd0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {lane_p1d, lane_p1, lane_p0d, lane_p0}, 32'd0);
    check("R11", {28'd0, lane_oe}, {28'd0, 4'b0101});
    check("R11", {30'd0, dclk_wave}, 32'd0);
    #1 rst_n = 1'b1;
    run_mode(1'b0, 1'b0, 1'b0, 1'b0, 10, 4'd3, 4'd6); // R3 R6 falling
    run_mode(1'b1, 1'b0, 1'b0, 1'b1, 10, 4'd3, 4'd6); // R3 R6 rising
    run_mode(1'b0, 1'b1, 1'b0, 1'b1, 12, 4'd4, 4'd7); // R4 R7 rising
    run_mode(1'b1, 1'b1, 1'b0, 1'b0, 12, 4'd5, 4'd7); // R5 R7 falling
    run_mode(1'b0, 1'b1, 1'b1, 1'b0, 10, 4'd10, 4'd8); // R10: sdr demux pin ignored
    run_mode(1'b0, 1'b0, 1'b1, 1'b1, 14, 4'd10, 4'd9); // R10 R2: long delay 4
    run_mode(1'b1, 1'b0, 1'b1, 1'b1, 14, 4'd5, 4'd9);  // R5 R9
    run_mode(1'b1, 1'b0, 1'b1, 1'b0, 10, 4'd3, 4'd8);  // R3 R8
    repeat (3) @(negedge clk);
    if (sb.size() != 0) check("R2", 32'(sb.size()), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule